// File: doc/BRIEF.md
# CPU hotplug register controller

This block holds hot-add and hot-remove state for a fixed set of processor slots and exposes it to host software through a small byte-addressed register window. Software picks a slot through a selector register, reads that slot's flag byte, acknowledges or triggers events by writing the same byte, and uses a command register to change what the 32-bit data window means. The data window can return the selector, the slot's 64-bit architecture ID, or accept OS status-report words.

Platform logic drives three side-band pulses, each with a slot index: a slot was hot-plugged, removal of a slot was requested, and a slot was finally unplugged. The block raises a level interrupt while any insert or remove event is pending. It emits a one-cycle eject strobe with the slot index when software ejects a slot, and a one-cycle notification strobe when software writes an OS status word. Command 0 searches circularly from the current selector for the next slot with a pending event and moves the selector to that slot. Software can therefore walk every event with one command per slot.

Bus accesses carry a start offset, a size of 1 to 4 bytes and little-endian data right-aligned in a 32-bit word. Decoding uses the start offset only. Slot 0 is the boot processor. A reset-time mask parameter sets which slots start populated.

Top module: `cpuhp_regs`

## Requirements
- R1: After reset the selector and command are 0, populated slots equal the boot mask (slot 0 only by default), no event is pending, the interrupt is low and neither strobe is active.
- R2: A read at offset 4 returns the selected slot's flags: bit0 populated, bit1 insert pending, bit2 remove pending, bit4 firmware-remove requested. All other bits are 0.
- R3: A write at offset 4 is decoded in priority order on its low byte: bit1 clears insert pending; otherwise bit2 clears remove pending; otherwise bit3 ejects the slot; otherwise bit4 sets firmware-remove.
- R4: Eject and firmware-remove are refused when the selected slot is unpopulated or is slot 0. An accepted eject pulses `eject_o` for one cycle in the cycle after the write, with the slot index on `eject_slot_o`, and clears firmware-remove. Populated is left set until the unplug input arrives.
- R5: While the selector is at or beyond the slot count, every read returns 0 and every write other than to offset 0 is ignored.
- R6: A command write (offset 5) with a value of 4 or more leaves the command register unchanged. Values 0..3 select: 0 find next event, 1 OST event write, 2 OST status write, 3 architecture ID read.
- R7: Writing command 0 scans the slots from the current selector upward, wrapping to 0. The first slot with insert, remove or firmware-remove pending becomes the selector. If no slot has an event, the selector is unchanged.
- R8: A read at offset 8 returns the selector under command 0, the low 32 ID bits under command 3, and 0 otherwise. A read at offset 0 returns 0 under command 0, the high 32 ID bits under command 3, and 0 otherwise.
- R9: A data write under command 1 stores the slot's OST event word. Under command 2 it stores the OST status word and pulses `ost_valid_o` for one cycle in the following cycle, carrying the slot, the stored event and the new status.
- R10: A plug pulse sets populated and insert pending. An unplug-request pulse sets remove pending. An unplug pulse clears populated. A side-band set takes precedence over a same-cycle software clear.
- R11: `evt_irq_o` is high exactly while some slot has insert or remove pending. Firmware-remove alone does not raise it. A plug pulse makes it high in the next cycle.
- R12: Write data is truncated to the access size and read data is masked to it (size code 0..3 means 1..4 bytes). A write whose start offset is not 0, 4, 5 or 8 has no effect. A multi-byte write at offset 4 updates only the flags, not the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte start offset |
| bus_size_i | input | 2 | Access size minus one, in bytes |
| bus_wdata_i | input | 32 | Write data, right-aligned |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| plug_valid_i | input | 1 | Slot hot-plugged pulse |
| plug_slot_i | input | IDX_W | Slot of the plug pulse |
| unplug_req_valid_i | input | 1 | Removal requested pulse |
| unplug_req_slot_i | input | IDX_W | Slot of the removal request |
| unplug_valid_i | input | 1 | Slot removed pulse |
| unplug_slot_i | input | IDX_W | Slot of the removal |
| arch_id_i | input | 64*NUM_SLOTS | Architecture ID per slot, slot k at bits 64k+63..64k |
| evt_irq_o | output | 1 | Event interrupt level |
| eject_o | output | 1 | Eject strobe |
| eject_slot_o | output | IDX_W | Slot being ejected |
| ost_valid_o | output | 1 | OS status notification strobe |
| ost_slot_o | output | IDX_W | Slot of the notification |
| ost_event_o | output | 32 | Stored OST event word |
| ost_status_o | output | 32 | New OST status word |

## Verification
The circular search is run with the start slot itself pending, with pending slots both below and above the start so that only wrapping reaches the first hit, with no event anywhere, and with only a firmware-remove flag pending. These cases separate a correct circular scan from a forward-only scan, a scan that skips its starting slot, and one that ignores the firmware flag. Flag writes set several bits at once so that the decode priority is visible. Ejects target a populated slot, an empty slot and the boot slot. An out-of-range selector whose low bits alias a real slot shows whether the range check truly gates writes.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

  typedef enum logic [1:0] {
    CMD_SCAN    = 2'd0,
    CMD_OST_EV  = 2'd1,
    CMD_OST_ST  = 2'd2,
    CMD_ARCH_ID = 2'd3
  } cmd_e;

  localparam logic [3:0] OFF_SEL   = 4'd0;
  localparam logic [3:0] OFF_FLAGS = 4'd4;
  localparam logic [3:0] OFF_CMD   = 4'd5;
  localparam logic [3:0] OFF_DATA  = 4'd8;

  localparam int CMD_COUNT = 4;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      2'd2:    size_mask = 32'h00FF_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cpuhp_bus_decode.sv
module cpuhp_bus_decode
  import cpuhp_pkg::*;
(
  input  logic        valid_i,
  input  logic        write_i,
  input  logic [3:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic        sel_ok_i,
  output logic        wr_sel_o,
  output logic        wr_flags_o,
  output logic        wr_cmd_o,
  output logic        wr_data_o,
  output logic        rd_o,
  output logic [31:0] wdata_o,
  output logic [31:0] mask_o
);

  logic wr_any;

  always_comb begin
    mask_o     = size_mask(size_i);
    wdata_o    = wdata_i & mask_o;
    wr_any     = valid_i && write_i;
    rd_o       = valid_i && !write_i;
    wr_sel_o   = wr_any && (addr_i == OFF_SEL);
    wr_flags_o = wr_any && sel_ok_i && (addr_i == OFF_FLAGS);
    wr_cmd_o   = wr_any && sel_ok_i && (addr_i == OFF_CMD);
    wr_data_o  = wr_any && sel_ok_i && (addr_i == OFF_DATA);
  end

endmodule

// File: rtl/cpuhp_ring_scan.sv
module cpuhp_ring_scan #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic [IDX_W-1:0]     start_i,
  input  logic [NUM_SLOTS-1:0] pend_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);

  always_comb begin
    int pos;
    hit_o = 1'b0;
    idx_o = '0;
    pos   = 0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      pos = int'(start_i) + k;
      if (pos >= NUM_SLOTS) pos = pos - NUM_SLOTS;
      if (pend_i[pos]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    if (hit_o) begin
      p_scan_hit_r7: assert (pend_i[idx_o]);
    end
  end

endmodule

// File: rtl/cpuhp_slot_bank.sv
module cpuhp_slot_bank #(
  parameter int                   NUM_SLOTS = 8,
  parameter int                   IDX_W     = 3,
  parameter logic [NUM_SLOTS-1:0] BOOT_MASK = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     sel_i,
  input  logic                 wr_flags_i,
  input  logic [4:1]           wflags_i,
  input  logic                 wr_ost_ev_i,
  input  logic                 wr_ost_st_i,
  input  logic [31:0]          wdata_i,
  input  logic                 plug_i,
  input  logic [IDX_W-1:0]     plug_slot_i,
  input  logic                 ureq_i,
  input  logic [IDX_W-1:0]     ureq_slot_i,
  input  logic                 unplug_i,
  input  logic [IDX_W-1:0]     unplug_slot_i,
  output logic [NUM_SLOTS-1:0] present_o,
  output logic [NUM_SLOTS-1:0] ins_o,
  output logic [NUM_SLOTS-1:0] rem_o,
  output logic [NUM_SLOTS-1:0] fw_o,
  output logic [31:0]          sel_ost_ev_o,
  output logic                 eject_fire_o
);

  logic clr_ins, clr_rem, ej_req, fw_req, target_ok, fw_fire;
  logic [31:0] ost_ev_q [NUM_SLOTS];
  logic [31:0] ost_st_q [NUM_SLOTS];

  always_comb begin
    clr_ins      = wr_flags_i && wflags_i[1];
    clr_rem      = wr_flags_i && !wflags_i[1] && wflags_i[2];
    ej_req       = wr_flags_i && !wflags_i[1] && !wflags_i[2] && wflags_i[3];
    fw_req       = wr_flags_i && !wflags_i[1] && !wflags_i[2] && !wflags_i[3] && wflags_i[4];
    target_ok    = present_o[sel_i] && (sel_i != '0);
    eject_fire_o = ej_req && target_ok;
    fw_fire      = fw_req && target_ok;
    sel_ost_ev_o = ost_ev_q[sel_i];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit, pres_d, ins_d, rem_d, fw_d;
    logic [31:0] ev_d, st_d;

    always_comb begin
      hit    = (sel_i == IDX_W'(i));
      pres_d = present_o[i];
      if (plug_i && plug_slot_i == IDX_W'(i))            pres_d = 1'b1;
      else if (unplug_i && unplug_slot_i == IDX_W'(i))   pres_d = 1'b0;
      ins_d = ins_o[i];
      if (plug_i && plug_slot_i == IDX_W'(i))            ins_d = 1'b1;
      else if (clr_ins && hit)                           ins_d = 1'b0;
      rem_d = rem_o[i];
      if (ureq_i && ureq_slot_i == IDX_W'(i))            rem_d = 1'b1;
      else if (clr_rem && hit)                           rem_d = 1'b0;
      fw_d = fw_o[i];
      if (fw_fire && hit)                                fw_d = 1'b1;
      else if (eject_fire_o && hit)                      fw_d = 1'b0;
      ev_d = (wr_ost_ev_i && hit) ? wdata_i : ost_ev_q[i];
      st_d = (wr_ost_st_i && hit) ? wdata_i : ost_st_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present_o[i] <= BOOT_MASK[i];
        ins_o[i]     <= 1'b0;
        rem_o[i]     <= 1'b0;
        fw_o[i]      <= 1'b0;
        ost_ev_q[i]  <= '0;
        ost_st_q[i]  <= '0;
      end else begin
        present_o[i] <= pres_d;
        ins_o[i]     <= ins_d;
        rem_o[i]     <= rem_d;
        fw_o[i]      <= fw_d;
        ost_ev_q[i]  <= ev_d;
        ost_st_q[i]  <= st_d;
      end
    end
  end

  p_no_boot_eject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eject_fire_o |-> (sel_i != '0) && present_o[sel_i]);

endmodule

// File: rtl/cpuhp_regs.sv
module cpuhp_regs
  import cpuhp_pkg::*;
#(
  parameter int                   NUM_SLOTS = 8,
  parameter logic [NUM_SLOTS-1:0] BOOT_MASK = 1,
  localparam int                  IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid_i,
  input  logic                     bus_write_i,
  input  logic [3:0]               bus_addr_i,
  input  logic [1:0]               bus_size_i,
  input  logic [31:0]              bus_wdata_i,
  output logic [31:0]              bus_rdata_o,
  input  logic                     plug_valid_i,
  input  logic [IDX_W-1:0]         plug_slot_i,
  input  logic                     unplug_req_valid_i,
  input  logic [IDX_W-1:0]         unplug_req_slot_i,
  input  logic                     unplug_valid_i,
  input  logic [IDX_W-1:0]         unplug_slot_i,
  input  logic [64*NUM_SLOTS-1:0]  arch_id_i,
  output logic                     evt_irq_o,
  output logic                     eject_o,
  output logic [IDX_W-1:0]         eject_slot_o,
  output logic                     ost_valid_o,
  output logic [IDX_W-1:0]         ost_slot_o,
  output logic [31:0]              ost_event_o,
  output logic [31:0]              ost_status_o
);

  logic [31:0]          sel_q, sel_d;
  cmd_e                 cmd_q, cmd_d;
  logic                 sel_ok;
  logic [IDX_W-1:0]     sel_idx;
  logic                 wr_sel, wr_flags, wr_cmd, wr_data, rd_req;
  logic [31:0]          wdata_m, rmask, rd_raw;
  logic                 cmd_legal;
  logic [NUM_SLOTS-1:0] present, ins, rem, fw, pend;
  logic                 scan_hit;
  logic [IDX_W-1:0]     scan_idx;
  logic [31:0]          sel_ost_ev;
  logic                 eject_fire;
  logic                 wr_ost_ev, wr_ost_st;
  logic [63:0]          sel_id;

  assign sel_ok  = (sel_q < 32'(NUM_SLOTS));
  assign sel_idx = sel_q[IDX_W-1:0];

  cpuhp_bus_decode i_dec (
    .valid_i    (bus_valid_i),
    .write_i    (bus_write_i),
    .addr_i     (bus_addr_i),
    .size_i     (bus_size_i),
    .wdata_i    (bus_wdata_i),
    .sel_ok_i   (sel_ok),
    .wr_sel_o   (wr_sel),
    .wr_flags_o (wr_flags),
    .wr_cmd_o   (wr_cmd),
    .wr_data_o  (wr_data),
    .rd_o       (rd_req),
    .wdata_o    (wdata_m),
    .mask_o     (rmask)
  );

  assign wr_ost_ev = wr_data && (cmd_q == CMD_OST_EV);
  assign wr_ost_st = wr_data && (cmd_q == CMD_OST_ST);

  cpuhp_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W),
    .BOOT_MASK (BOOT_MASK)
  ) i_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel_idx),
    .wr_flags_i    (wr_flags),
    .wflags_i      (wdata_m[4:1]),
    .wr_ost_ev_i   (wr_ost_ev),
    .wr_ost_st_i   (wr_ost_st),
    .wdata_i       (wdata_m),
    .plug_i        (plug_valid_i),
    .plug_slot_i   (plug_slot_i),
    .ureq_i        (unplug_req_valid_i),
    .ureq_slot_i   (unplug_req_slot_i),
    .unplug_i      (unplug_valid_i),
    .unplug_slot_i (unplug_slot_i),
    .present_o     (present),
    .ins_o         (ins),
    .rem_o         (rem),
    .fw_o          (fw),
    .sel_ost_ev_o  (sel_ost_ev),
    .eject_fire_o  (eject_fire)
  );

  assign pend = ins | rem | fw;

  cpuhp_ring_scan #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) i_scan (
    .start_i (sel_idx),
    .pend_i  (pend),
    .hit_o   (scan_hit),
    .idx_o   (scan_idx)
  );

  // next state of selector and command
  always_comb begin
    cmd_legal = (wdata_m < 32'(CMD_COUNT));
    cmd_d     = cmd_q;
    sel_d     = sel_q;
    if (wr_cmd && cmd_legal) cmd_d = cmd_e'(wdata_m[1:0]);
    if (wr_sel) begin
      sel_d = wdata_m;
    end else if (wr_cmd && cmd_legal && cmd_e'(wdata_m[1:0]) == CMD_SCAN && scan_hit) begin
      sel_d = {{(32-IDX_W){1'b0}}, scan_idx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cmd_q <= CMD_SCAN;
    end else begin
      sel_q <= sel_d;
      cmd_q <= cmd_d;
    end
  end

  // read path
  always_comb begin
    sel_id = arch_id_i[64*int'(sel_idx) +: 64];
    rd_raw = '0;
    if (sel_ok) begin
      case (bus_addr_i)
        OFF_SEL:   rd_raw = (cmd_q == CMD_ARCH_ID) ? sel_id[63:32] : 32'd0;
        OFF_FLAGS: rd_raw = {27'd0, fw[sel_idx], 1'b0, rem[sel_idx], ins[sel_idx], present[sel_idx]};
        OFF_DATA: begin
          if (cmd_q == CMD_SCAN)         rd_raw = sel_q;
          else if (cmd_q == CMD_ARCH_ID) rd_raw = sel_id[31:0];
        end
        default:   rd_raw = '0;
      endcase
    end
    bus_rdata_o = rd_req ? (rd_raw & rmask) : 32'd0;
  end

  assign evt_irq_o = |(ins | rem);

  // output strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eject_o      <= 1'b0;
      eject_slot_o <= '0;
      ost_valid_o  <= 1'b0;
      ost_slot_o   <= '0;
      ost_event_o  <= '0;
      ost_status_o <= '0;
    end else begin
      eject_o     <= eject_fire;
      ost_valid_o <= wr_ost_st;
      if (eject_fire) eject_slot_o <= sel_idx;
      if (wr_ost_st) begin
        ost_slot_o   <= sel_idx;
        ost_event_o  <= sel_ost_ev;
        ost_status_o <= wdata_m;
      end
    end
  end

  p_bad_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_write_i && sel_ok && bus_addr_i == OFF_CMD &&
     (bus_wdata_i & size_mask(bus_size_i)) >= 32'd4) |=> $stable(cmd_q));

  p_irq_plug_r11: assert property (@(posedge clk) disable iff (!rst_n)
    plug_valid_i |=> evt_irq_o);

  p_ost_note_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_write_i && sel_ok && bus_addr_i == OFF_DATA && cmd_q == CMD_OST_ST)
    |=> ost_valid_o);

  p_invalid_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && bus_valid_i && bus_write_i && bus_addr_i != OFF_SEL &&
     !plug_valid_i && !unplug_req_valid_i && !unplug_valid_i)
    |=> ($stable(pend) && $stable(present) && $stable(cmd_q) && $stable(sel_q)));

endmodule

// File: tb/test_cpuhp_regs.sv
`timescale 1ns/1ps
module test_cpuhp_regs;

  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_valid, bus_write;
  logic [3:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic plug_v, ureq_v, unplug_v;
  logic [IW-1:0] plug_s, ureq_s, unplug_s;
  logic [64*N-1:0] ids;
  logic irq, ej, ostv;
  logic [IW-1:0] ej_slot, ost_slot;
  logic [31:0] ost_ev, ost_st;

  int checks = 0;
  int fails = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  cpuhp_regs i_cpuhp_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_size_i(bus_size), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .plug_valid_i(plug_v), .plug_slot_i(plug_s),
    .unplug_req_valid_i(ureq_v), .unplug_req_slot_i(ureq_s),
    .unplug_valid_i(unplug_v), .unplug_slot_i(unplug_s),
    .arch_id_i(ids), .evt_irq_o(irq), .eject_o(ej), .eject_slot_o(ej_slot),
    .ost_valid_o(ostv), .ost_slot_o(ost_slot), .ost_event_o(ost_ev), .ost_status_o(ost_st)
  );

  function automatic logic [31:0] id_lo(int k); return 32'h0000_1000 + 32'(k); endfunction
  function automatic logic [31:0] id_hi(int k); return 32'hA000_0000 | 32'(k); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
    #2 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic pulse(input int kind, input int slot);
    @(negedge clk);
    case (kind)
      0: begin plug_v = 1'b1; plug_s = IW'(slot); end
      1: begin ureq_v = 1'b1; ureq_s = IW'(slot); end
      default: begin unplug_v = 1'b1; unplug_s = IW'(slot); end
    endcase
    @(negedge clk);
    plug_v = 1'b0; ureq_v = 1'b0; unplug_v = 1'b0;
  endtask

  task automatic t_reset();
    rd(4'd4, 2'd0, rv); chk("R1 flags slot0", rv, 32'h01);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 eject", 32'(ej), 0);
    rd(4'd8, 2'd3, rv); chk("R1 selector via data", rv, 0);
    wr(4'd0, 2'd3, 1);
    rd(4'd4, 2'd3, rv); chk("R1 slot1 empty", rv, 0);
    wr(4'd0, 2'd3, 0);
  endtask

  task automatic t_events();
    pulse(0, 3);
    chk("R11 irq after plug", 32'(irq), 1);
    wr(4'd0, 2'd3, 3);
    rd(4'd4, 2'd3, rv); chk("R10 R2 plug flags", rv, 32'h03);
    pulse(1, 3);
    rd(4'd4, 2'd3, rv); chk("R10 unplug request flags", rv, 32'h07);
    wr(4'd4, 2'd0, 32'h06);
    rd(4'd4, 2'd3, rv); chk("R3 bit1 wins over bit2", rv, 32'h05);
    chk("R11 irq with remove pending", 32'(irq), 1);
    wr(4'd4, 2'd0, 32'h04);
    rd(4'd4, 2'd3, rv); chk("R3 clear remove", rv, 32'h01);
    chk("R11 irq low", 32'(irq), 0);
  endtask

  task automatic t_eject();
    wr(4'd4, 2'd0, 32'h10);
    rd(4'd4, 2'd3, rv); chk("R3 set fw-remove", rv, 32'h11);
    chk("R11 fw alone no irq", 32'(irq), 0);
    wr(4'd4, 2'd0, 32'h18);
    chk("R4 eject strobe", 32'(ej), 1);
    chk("R4 eject slot", 32'(ej_slot), 3);
    @(negedge clk);
    chk("R4 eject one cycle", 32'(ej), 0);
    rd(4'd4, 2'd3, rv); chk("R4 eject clears fw, keeps present", rv, 32'h01);
    pulse(2, 3);
    rd(4'd4, 2'd3, rv); chk("R10 unplug clears present", rv, 32'h00);
    wr(4'd4, 2'd0, 32'h10);
    rd(4'd4, 2'd3, rv); chk("R4 fw refused on empty", rv, 32'h00);
    wr(4'd4, 2'd0, 32'h08);
    chk("R4 eject refused on empty", 32'(ej), 0);
    wr(4'd0, 2'd3, 0);
    wr(4'd4, 2'd0, 32'h08);
    chk("R4 eject refused on boot slot", 32'(ej), 0);
    wr(4'd4, 2'd0, 32'h10);
    rd(4'd4, 2'd3, rv); chk("R4 fw refused on boot slot", rv, 32'h01);
  endtask

  task automatic t_scan();
    pulse(0, 2); pulse(0, 5); pulse(0, 6);
    wr(4'd0, 2'd3, 6); wr(4'd5, 2'd0, 0);
    rd(4'd8, 2'd3, rv); chk("R7 start slot pending", rv, 6);
    rd(4'd0, 2'd3, rv); chk("R8 second word under cmd0", rv, 0);
    wr(4'd4, 2'd0, 32'h02);
    wr(4'd5, 2'd0, 0);
    rd(4'd8, 2'd3, rv); chk("R7 wrap to lower slot", rv, 2);
    wr(4'd4, 2'd0, 32'h02);
    wr(4'd0, 2'd3, 5); wr(4'd4, 2'd0, 32'h02);
    wr(4'd0, 2'd3, 4); wr(4'd5, 2'd0, 0);
    rd(4'd8, 2'd3, rv); chk("R7 no event keeps selector", rv, 4);
    chk("R11 irq low after clears", 32'(irq), 0);
    wr(4'd0, 2'd3, 5); wr(4'd4, 2'd0, 32'h10);
    wr(4'd0, 2'd3, 7); wr(4'd5, 2'd0, 0);
    rd(4'd8, 2'd3, rv); chk("R7 fw-remove counts as event", rv, 5);
  endtask

  task automatic t_cmd();
    wr(4'd5, 2'd0, 3);
    rd(4'd8, 2'd3, rv); chk("R8 id low", rv, id_lo(5));
    rd(4'd0, 2'd3, rv); chk("R8 id high", rv, id_hi(5));
    wr(4'd5, 2'd0, 7);
    rd(4'd8, 2'd3, rv); chk("R6 illegal command ignored", rv, id_lo(5));
    rd(4'd8, 2'd0, rv); chk("R12 one-byte read mask", rv, id_lo(5) & 32'hFF);
    wr(4'd5, 2'd0, 1);
    rd(4'd8, 2'd3, rv); chk("R8 data reads 0 under cmd1", rv, 0);
  endtask

  task automatic t_ost();
    wr(4'd0, 2'd3, 2);
    wr(4'd5, 2'd0, 1); wr(4'd8, 2'd3, 32'h11);
    chk("R9 no note on event write", 32'(ostv), 0);
    wr(4'd5, 2'd0, 2); wr(4'd8, 2'd3, 32'h22);
    chk("R9 note strobe", 32'(ostv), 1);
    chk("R9 note slot", 32'(ost_slot), 2);
    chk("R9 note event", ost_ev, 32'h11);
    chk("R9 note status", ost_st, 32'h22);
    @(negedge clk);
    chk("R9 note one cycle", 32'(ostv), 0);
    wr(4'd8, 2'd0, 32'h1234_5680);
    chk("R12 status truncated to one byte", ost_st, 32'h80);
  endtask

  task automatic t_invalid();
    wr(4'd5, 2'd0, 3);
    pulse(1, 5);
    wr(4'd0, 2'd3, 9);
    rd(4'd4, 2'd3, rv); chk("R5 flags read 0", rv, 0);
    rd(4'd8, 2'd3, rv); chk("R5 data read 0", rv, 0);
    rd(4'd0, 2'd3, rv); chk("R5 second word 0", rv, 0);
    wr(4'd5, 2'd0, 0);
    wr(4'd0, 2'd3, 13);
    wr(4'd4, 2'd0, 32'h04);
    wr(4'd0, 2'd3, 5);
    rd(4'd4, 2'd3, rv); chk("R5 aliasing flag write ignored", rv, 32'h15);
    rd(4'd8, 2'd3, rv); chk("R5 command write ignored", rv, id_lo(5));
  endtask

  task automatic t_size();
    wr(4'd6, 2'd0, 32'h04);
    rd(4'd4, 2'd3, rv); chk("R12 unaligned write ignored", rv, 32'h15);
    wr(4'd4, 2'd1, 32'h0000_0104);
    rd(4'd4, 2'd3, rv); chk("R12 wide flags write", rv, 32'h11);
    rd(4'd8, 2'd3, rv); chk("R12 wide flags write leaves cmd", rv, id_lo(5));
    wr(4'd0, 2'd0, 32'hFFFF_FF02);
    rd(4'd8, 2'd3, rv); chk("R12 one-byte selector write", rv, id_lo(2));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) ids[k*64 +: 64] = {id_hi(k), id_lo(k)};
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; plug_v = 1'b0; ureq_v = 1'b0; unplug_v = 1'b0;
    plug_s = '0; ureq_s = '0; unplug_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_eject();
    t_scan();
    t_cmd();
    t_ost();
    t_invalid();
    t_size();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule